// File: doc/BRIEF.md
# Integer Execution Unit with Signed-Overflow Trap

This block is the integer arithmetic and logic stage of a small RISC core. Each operation takes one source register value and a second operand. The second operand is either another register value or a 16-bit immediate. The unit returns a result, a destination write-enable and a one-cycle overflow-exception pulse. Instruction decode, the register file and exception vectoring sit outside the block. An opcode select input and an immediate-select input drive it directly.

Addition comes in two forms. The trapping form treats its operands as signed. When the sum overflows, it raises the exception and holds back the destination write. The non-trapping form always writes the wrapped sum. Subtraction wraps silently. AND produces the bitwise conjunction of its operands. Absolute value passes a non-negative source through unchanged and otherwise returns zero minus the source. All outputs are registered, so a result appears one clock after the operation is presented.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_q`, `wr_en_q` and `ovf_q` are all zero after that edge.
- R2: Timing: an operation presented with `in_valid` high is reflected on the outputs after the next rising edge. Trapping add, op code 0: `res_q` is the 32-bit sum and `wr_en_q` is 1 when no signed overflow occurs.
- R3: For op code 0, signed overflow is two operands of equal sign giving a sum of the other sign. On overflow, `ovf_q` is 1 for exactly that one cycle, `wr_en_q` is 0, and `res_q` carries the wrapped sum.
- R4: Non-trapping add, op code 1, writes the wrapped 32-bit sum with `wr_en_q` = 1 and never raises `ovf_q`.
- R5: AND, op code 2, gives the bitwise AND of its operands with `wr_en_q` = 1. Its 16-bit immediate is zero-extended.
- R6: With `use_imm` = 1, the second operand comes from `imm` instead of `src_b`. For op codes 0, 1 and 3, `imm` is sign-extended from bit 15.
- R7: Subtract, op code 3, gives the wrapped difference `src_a` − operand with `wr_en_q` = 1 and never raises `ovf_q`.
- R8: Absolute value, op code 4, returns `src_a` when bit 31 of `src_a` is 0 and 0 − `src_a` otherwise, with `wr_en_q` = 1. The second operand has no effect.
- R9: The absolute value of 0x80000000 is 0x80000000, with `wr_en_q` = 1 and `ovf_q` = 0.
- R10: For a cycle with `in_valid` = 0, or with op codes 5 to 7, the following cycle shows `wr_en_q` = 0 and `ovf_q` = 0, and `res_q` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Operation code (0 trap add, 1 wrap add, 2 AND, 3 subtract, 4 absolute) |
| use_imm | input | 1 | Take the second operand from `imm` |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| imm | input | 16 | Immediate field |
| res_q | output | 32 | Registered result |
| wr_en_q | output | 1 | Registered destination write-enable |
| ovf_q | output | 1 | Registered overflow-exception pulse |

## Verification
The bench builds the unit with its default widths: a 32-bit datapath and a 16-bit immediate. These widths make the exact overflow boundaries reachable. They include the largest positive value plus one, the most negative value plus minus one, and the absolute value of the most negative value. The same widths place bit 15 of the immediate at the seam where sign extension and zero extension give different operands. The vectors therefore sit on both sides of each of those edges.

// File: rtl/xu_pkg.sv
package xu_pkg;
  typedef enum logic [2:0] {
    OP_ADD_TRAP = 3'd0,
    OP_ADD_WRAP = 3'd1,
    OP_AND      = 3'd2,
    OP_SUB      = 3'd3,
    OP_ABS      = 3'd4
  } xu_op_e;

  localparam int unsigned OP_W     = 3;
  localparam int unsigned OP_LAST  = 4;
endpackage

// File: rtl/xu_operand_sel.sv
module xu_operand_sel
  import xu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] reg_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] opnd_b_o
);
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  logic              is_logic_op;
  logic [EXT_W-1:0]  ext_bits;

  // logic immediates are zero-extended, arithmetic ones sign-extended
  assign is_logic_op = (op_i == OP_W'(OP_AND));
  assign ext_bits    = is_logic_op ? '0 : {EXT_W{imm_i[IMM_W-1]}};

  always_comb begin
    if (use_imm_i) opnd_b_o = {ext_bits, imm_i};
    else           opnd_b_o = reg_b_i;
  end
endmodule

// File: rtl/xu_arith.sv
module xu_arith
  import xu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              known_o,
  output logic              trap_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] negated;
  logic              sum_sovf;

  assign sum      = a_i + b_i;
  assign diff     = a_i - b_i;
  assign negated  = '0 - a_i;
  assign sum_sovf = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);

  always_comb begin
    res_o   = '0;
    known_o = 1'b1;
    trap_o  = 1'b0;
    unique case (op_i)
      OP_W'(OP_ADD_TRAP): begin
        res_o  = sum;
        trap_o = sum_sovf;
      end
      OP_W'(OP_ADD_WRAP): res_o = sum;
      OP_W'(OP_AND):      res_o = a_i & b_i;
      OP_W'(OP_SUB):      res_o = diff;
      OP_W'(OP_ABS):      res_o = a_i[MSB] ? negated : a_i;
      default:            known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import xu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] res_q,
  output logic              wr_en_q,
  output logic              ovf_q
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_res;
  logic              alu_known;
  logic              alu_trap;

  xu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .op_i      (op_sel),
    .use_imm_i (use_imm),
    .reg_b_i   (src_b),
    .imm_i     (imm),
    .opnd_b_o  (opnd_b)
  );

  xu_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i    (op_sel),
    .a_i     (src_a),
    .b_i     (opnd_b),
    .res_o   (alu_res),
    .known_o (alu_known),
    .trap_o  (alu_trap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      wr_en_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      wr_en_q <= in_valid && alu_known && !alu_trap;
      ovf_q   <= in_valid && alu_trap;
      if (in_valid && alu_known) res_q <= alu_res;
    end
  end

  // an exception never accompanies a register write
  p_no_write_on_ovf_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> !wr_en_q);

  // only the trapping add may raise the exception
  p_ovf_only_trap_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> ($past(in_valid) && $past(op_sel) == OP_W'(OP_ADD_TRAP)));

  // quiet cycle: no write, no exception, result held
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wr_en_q && !ovf_q));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_q));

  // absolute value is non-negative except for the most negative input
  p_abs_nonneg_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_W'(OP_ABS) && src_a != {1'b1, {MSB{1'b0}}})
      |=> !res_q[MSB]);

  // subtraction never traps
  p_sub_no_trap_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_W'(OP_SUB)) |=> (!ovf_q && wr_en_q));
endmodule

// File: tb/int_exec_unit_bench.sv
`timescale 1ns/1ps
module int_exec_unit_bench;
  localparam int NV = 18;
  // fields: tag[3:0] op[2:0] imm_sel a[31:0] b[31:0] imm[15:0] exp_res[31:0] exp_we exp_ovf
  localparam logic [121:0] VECS [NV] = '{
    {4'd2, 3'd0, 1'b0, 32'h00000005, 32'h00000007, 16'h0000, 32'h0000000C, 1'b1, 1'b0}, // R2
    {4'd3, 3'd0, 1'b0, 32'h7FFFFFFF, 32'h00000001, 16'h0000, 32'h80000000, 1'b0, 1'b1}, // R3
    {4'd3, 3'd0, 1'b0, 32'h80000000, 32'hFFFFFFFF, 16'h0000, 32'h7FFFFFFF, 1'b0, 1'b1}, // R3
    {4'd2, 3'd0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0000, 32'hFFFFFFFE, 1'b1, 1'b0}, // R2
    {4'd4, 3'd1, 1'b0, 32'h7FFFFFFF, 32'h00000001, 16'h0000, 32'h80000000, 1'b1, 1'b0}, // R4
    {4'd6, 3'd0, 1'b1, 32'h00000010, 32'h12345678, 16'hFFFF, 32'h0000000F, 1'b1, 1'b0}, // R6
    {4'd6, 3'd0, 1'b1, 32'h7FFFFFFF, 32'h00000000, 16'h0001, 32'h80000000, 1'b0, 1'b1}, // R6 R3
    {4'd6, 3'd1, 1'b1, 32'h00000000, 32'h00000005, 16'h8000, 32'hFFFF8000, 1'b1, 1'b0}, // R6
    {4'd5, 3'd2, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 32'hF000F000, 1'b1, 1'b0}, // R5
    {4'd5, 3'd2, 1'b1, 32'hFFFFFFFF, 32'h00000000, 16'h8001, 32'h00008001, 1'b1, 1'b0}, // R5
    {4'd7, 3'd3, 1'b0, 32'h00000003, 32'h00000005, 16'h0000, 32'hFFFFFFFE, 1'b1, 1'b0}, // R7
    {4'd7, 3'd3, 1'b0, 32'h80000000, 32'h00000001, 16'h0000, 32'h7FFFFFFF, 1'b1, 1'b0}, // R7
    {4'd7, 3'd3, 1'b1, 32'h00000000, 32'h00000000, 16'hFFFF, 32'h00000001, 1'b1, 1'b0}, // R7 R6
    {4'd8, 3'd4, 1'b0, 32'hFFFFFFF6, 32'h00000123, 16'h0000, 32'h0000000A, 1'b1, 1'b0}, // R8
    {4'd8, 3'd4, 1'b1, 32'h00000009, 32'h00000000, 16'h8000, 32'h00000009, 1'b1, 1'b0}, // R8
    {4'd9, 3'd4, 1'b0, 32'h80000000, 32'h00000000, 16'h0000, 32'h80000000, 1'b1, 1'b0}, // R9
    {4'd10,3'd5, 1'b0, 32'h00000001, 32'h00000001, 16'h0000, 32'h80000000, 1'b0, 1'b0}, // R10
    {4'd8, 3'd4, 1'b0, 32'h00000000, 32'hFFFFFFFF, 16'h0000, 32'h00000000, 1'b1, 1'b0}  // R8
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        use_imm = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm = '0;
  logic [31:0] res_q;
  logic        wr_en_q;
  logic        ovf_q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  int_exec_unit u_int_exec_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .use_imm(use_imm),
    .src_a(src_a), .src_b(src_b), .imm(imm),
    .res_q(res_q), .wr_en_q(wr_en_q), .ovf_q(ovf_q)
  );

  task automatic check(input string req, input logic [31:0] er, input logic ew, input logic eo);
    n_run++;
    if (res_q !== er || wr_en_q !== ew || ovf_q !== eo) begin
      n_fail++;
      $display("FAIL %s: got res=%h we=%b ovf=%b, expected res=%h we=%b ovf=%b",
               req, res_q, wr_en_q, ovf_q, er, ew, eo);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [121:0] v;
      v = VECS[i];
      @(negedge clk);
      in_valid = 1'b1;
      op_sel   = v[117:115];
      use_imm  = v[114];
      src_a    = v[113:82];
      src_b    = v[81:50];
      imm      = v[49:34];
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vector %0d", v[121:118], i), v[33:2], v[1], v[0]);
    end

    // R10: idle cycle keeps result, no write
    @(negedge clk);
    check("R10 idle hold", 32'h0, 1'b0, 1'b0);

    // R3: overflow pulse lasts a single cycle
    in_valid = 1'b1; op_sel = 3'd0; use_imm = 1'b0;
    src_a = 32'h80000000; src_b = 32'h80000000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 trap", 32'h0, 1'b0, 1'b1);
    @(negedge clk);
    check("R3 single pulse", 32'h0, 1'b0, 1'b0);

    // R10: op code 7 with in_valid high leaves result alone
    in_valid = 1'b1; op_sel = 3'd7; src_a = 32'h1234; src_b = 32'h1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 undefined op", 32'h0, 1'b0, 1'b0);

    // R4 then R1: write a value, then reset clears it
    in_valid = 1'b1; op_sel = 3'd1; src_a = 32'hFFFFFFFF; src_b = 32'h2;
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 wrap add", 32'h00000001, 1'b1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule